// File: doc/BRIEF.md
# Strap-Loaded Station Address and Mode Configuration

This block keeps the station address and operating-mode configuration of a 10/100 Ethernet transceiver, and it decides whether a management transaction is addressed to this device. The first rising clock edge after the active-low hardware reset is released is the capture edge. On that edge the block samples one address strap pin and a three-bit mode strap bus. Only the lowest address bit comes from a strap, so after reset the stored address is 0 or 1. The mode bits are loaded into the configuration register at the same moment.

Once the capture edge has passed, the strap pin becomes the receive-error output. The block holds that pin's output enable low during reset so that the strap level can be read. A synchronous register port lets software change three things: the full five-bit address, the mode bits and an address-bypass control. The bypass control makes write transactions match whatever address they carry. A soft reset issued through the control register clears the bypass control. It does not sample the strap pins again. The stored address is also driven out as the seed for the transmit scrambler.

Top module: `phy_strap_cfg`

## Requirements
- R1: On the first rising clock edge after `rst_n` goes high, bit 0 of the stored address takes the value of `strap_rxer_i`. Address bits [4:1] are zero after that edge.
- R2: On that same edge, the stored mode takes the value of `mode_strap`. The stored mode reads back in bits [7:5] of register 18.
- R3: While `rst_n` is low, and until the capture edge, `rxer_oe` and `rxer_o` are both 0. After the capture edge, `rxer_oe` is 1 and `rxer_o` follows `rx_err`.
- R4: A write to register 18 loads the stored address from `reg_wdata[4:0]` and the stored mode from `reg_wdata[7:5]`. The new values can be seen one clock later. Any value from 0 to 31 is accepted.
- R5: A write to register 17 loads the bypass control from `reg_wdata[3]`.
- R6: A write to register 0 with `reg_wdata[15]` set clears the bypass control. It leaves the stored address and mode unchanged and does not sample the strap pins again. A write to register 0 with bit 15 clear changes nothing.
- R7: When `frame_valid` is high, `frame_match` is 1 whenever `frame_addr` equals the stored address. This holds for both reads and writes.
- R8: When the bypass control is 1 and `frame_is_write` is 1, `frame_match` is 1 for every value of `frame_addr`. Reads still need an equal address.
- R9: `frame_match` is 0 whenever `frame_valid` is 0.
- R10: `scr_seed` always equals the stored address.
- R11: `reg_rdata` is combinational from `reg_rsel`. Register 17 returns the bypass control in bit 3. Register 18 returns the mode in bits [7:5] and the address in bits [4:0]. Every other bit, and every other register, reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset, asynchronous assert |
| strap_rxer_i | input | 1 | Level on the shared address-strap / receive-error pin |
| mode_strap | input | 3 | Mode strap bus |
| rx_err | input | 1 | Internal receive-error indication to drive onto the shared pin |
| rxer_o | output | 1 | Output value for the shared pin |
| rxer_oe | output | 1 | Output enable for the shared pin |
| reg_we | input | 1 | Register write strobe |
| reg_wsel | input | 5 | Register number for the write |
| reg_wdata | input | 16 | Write data |
| reg_rsel | input | 5 | Register number for the read |
| reg_rdata | output | 16 | Read data |
| frame_valid | input | 1 | Management transaction address is valid |
| frame_addr | input | 5 | Address field of the transaction |
| frame_is_write | input | 1 | 1 = write transaction, 0 = read |
| frame_match | output | 1 | Transaction is for this device |
| mode_cfg | output | 3 | Stored mode |
| scr_seed | output | 5 | Stored address, used as the scrambler seed |

## Verification
The reset sweep covers every combination of the two strap levels and the eight mode codes. It tells bit 0 of the address apart from the mode field, and it separates the reset window from the first cycle after capture. The match logic is tested with all 32 stored addresses against all 32 frame addresses. Each of those pairs is tried with both transaction directions, with the valid flag high and low, and with the bypass control on and off. This sweep separates the equality term from the bypass term, and the write-only bypass from a bypass that would also cover reads. Soft reset is tried after the strap pins have been moved to new levels. This shows whether the block keeps the register contents or samples the pins again.

// File: rtl/phy_strap_cfg_pkg.sv
package phy_strap_cfg_pkg;
  localparam int unsigned ADDR_W     = 5;
  localparam int unsigned MODE_W     = 3;
  localparam int unsigned DATA_W     = 16;
  localparam int unsigned RSEL_W     = 5;
  localparam int unsigned REG_CTRL   = 0;
  localparam int unsigned REG_MCSR   = 17;
  localparam int unsigned REG_SPEC   = 18;
  localparam int unsigned BYPASS_BIT = 3;
  localparam int unsigned SRST_BIT   = 15;
  localparam int unsigned MODE_LSB   = 5;
endpackage

// File: rtl/strap_sampler.sv
module strap_sampler (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_err,
  output logic load,
  output logic rxer_o,
  output logic rxer_oe
);
  logic armed_q;
  logic armed_d;

  always_comb begin
    armed_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
    end else if (!armed_q) begin
      armed_q <= armed_d;
    end
  end

  // The capture edge is the first edge seen while still unarmed.
  assign load    = !armed_q;
  assign rxer_oe = armed_q;
  assign rxer_o  = armed_q & rx_err;

  // R3: the pin stays an input for exactly one edge after release
  a_r3_oe_after_capture: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(load) |-> rxer_oe);
  a_r3_quiet_when_input: assert property (@(posedge clk) disable iff (!rst_n)
    !rxer_oe |-> !rxer_o);
endmodule

// File: rtl/cfg_regs.sv
module cfg_regs
  import phy_strap_cfg_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned MW = MODE_W,
  parameter int unsigned DW = DATA_W,
  parameter int unsigned SW = RSEL_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          strap_bit0,
  input  logic [MW-1:0] mode_pins,
  input  logic          we,
  input  logic [SW-1:0] wsel,
  input  logic [DW-1:0] wdata,
  input  logic [SW-1:0] rsel,
  output logic [DW-1:0] rdata,
  output logic [AW-1:0] dev_addr,
  output logic [MW-1:0] mode_q,
  output logic          bypass
);
  localparam logic [SW-1:0] SEL_CTRL = SW'(REG_CTRL);
  localparam logic [SW-1:0] SEL_MCSR = SW'(REG_MCSR);
  localparam logic [SW-1:0] SEL_SPEC = SW'(REG_SPEC);

  logic [AW-1:0] addr_q, addr_d;
  logic [MW-1:0] mode_r, mode_d;
  logic          byp_q, byp_d;
  logic          cfg_en;

  logic unused_wdata_bits;
  assign unused_wdata_bits = ^wdata[SRST_BIT-1:MODE_LSB+MW];

  assign cfg_en = load | we;

  always_comb begin
    addr_d = addr_q;
    mode_d = mode_r;
    byp_d  = byp_q;
    if (load) begin
      addr_d = {{(AW-1){1'b0}}, strap_bit0};
      mode_d = mode_pins;
    end else if (we) begin
      if (wsel == SEL_SPEC) begin
        addr_d = wdata[AW-1:0];
        mode_d = wdata[MODE_LSB +: MW];
      end else if (wsel == SEL_MCSR) begin
        byp_d = wdata[BYPASS_BIT];
      end else if (wsel == SEL_CTRL && wdata[SRST_BIT]) begin
        byp_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      mode_r <= '0;
      byp_q  <= 1'b0;
    end else if (cfg_en) begin
      addr_q <= addr_d;
      mode_r <= mode_d;
      byp_q  <= byp_d;
    end
  end

  always_comb begin
    rdata = '0;
    if (rsel == SEL_SPEC) begin
      rdata[AW-1:0]        = addr_q;
      rdata[MODE_LSB +: MW] = mode_r;
    end else if (rsel == SEL_MCSR) begin
      rdata[BYPASS_BIT] = byp_q;
    end
  end

  assign dev_addr = addr_q;
  assign mode_q   = mode_r;
  assign bypass   = byp_q;

  // R1 / R2: strap levels seen on the capture edge are what is held after it
  a_r1_strap_addr: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(load) |-> addr_q == {{(AW-1){1'b0}}, $past(strap_bit0)});
  a_r2_strap_mode: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(load) |-> mode_r == $past(mode_pins));
  // R4: address register write lands one clock later
  a_r4_addr_write: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !load && wsel == SEL_SPEC) |=> addr_q == $past(wdata[AW-1:0]));
  // R6: soft reset keeps address and mode
  a_r6_soft_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !load && wsel == SEL_CTRL && wdata[SRST_BIT])
      |=> ($stable(addr_q) && $stable(mode_r) && !byp_q));
endmodule

// File: rtl/addr_match.sv
module addr_match #(
  parameter int unsigned AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          valid,
  input  logic [AW-1:0] frame_addr,
  input  logic          is_write,
  input  logic [AW-1:0] dev_addr,
  input  logic          bypass,
  output logic          match
);
  logic addr_eq;
  logic wr_skip;

  always_comb begin
    addr_eq = (frame_addr == dev_addr);
    wr_skip = bypass & is_write;
    match   = valid & (addr_eq | wr_skip);
  end

  // R9: nothing matches without a valid frame
  a_r9_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    match |-> valid);
  // R8: a read never matches a different address, bypass or not
  a_r8_read_exact: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !is_write && frame_addr != dev_addr) |-> !match);
endmodule

// File: rtl/phy_strap_cfg.sv
module phy_strap_cfg
  import phy_strap_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strap_rxer_i,
  input  logic [MODE_W-1:0] mode_strap,
  input  logic              rx_err,
  output logic              rxer_o,
  output logic              rxer_oe,
  input  logic              reg_we,
  input  logic [RSEL_W-1:0] reg_wsel,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic [RSEL_W-1:0] reg_rsel,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              frame_valid,
  input  logic [ADDR_W-1:0] frame_addr,
  input  logic              frame_is_write,
  output logic              frame_match,
  output logic [MODE_W-1:0] mode_cfg,
  output logic [ADDR_W-1:0] scr_seed
);
  logic              load;
  logic [ADDR_W-1:0] dev_addr;
  logic              bypass;

  strap_sampler u_sampler (
    .clk     (clk),
    .rst_n   (rst_n),
    .rx_err  (rx_err),
    .load    (load),
    .rxer_o  (rxer_o),
    .rxer_oe (rxer_oe)
  );

  cfg_regs #(
    .AW (ADDR_W),
    .MW (MODE_W),
    .DW (DATA_W),
    .SW (RSEL_W)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (load),
    .strap_bit0 (strap_rxer_i),
    .mode_pins  (mode_strap),
    .we         (reg_we),
    .wsel       (reg_wsel),
    .wdata      (reg_wdata),
    .rsel       (reg_rsel),
    .rdata      (reg_rdata),
    .dev_addr   (dev_addr),
    .mode_q     (mode_cfg),
    .bypass     (bypass)
  );

  addr_match #(
    .AW (ADDR_W)
  ) u_match (
    .clk        (clk),
    .rst_n      (rst_n),
    .valid      (frame_valid),
    .frame_addr (frame_addr),
    .is_write   (frame_is_write),
    .dev_addr   (dev_addr),
    .bypass     (bypass),
    .match      (frame_match)
  );

  assign scr_seed = dev_addr;

  // R7: a valid frame carrying the seed address always matches
  a_r7_equal_matches: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_valid && frame_addr == scr_seed) |-> frame_match);
endmodule

// File: tb/tb_phy_strap_cfg.sv
module tb_phy_strap_cfg;
  localparam time CLK_PERIOD = 10ns;

  logic        clk;
  logic        rst_n;
  logic        strap_rxer_i;
  logic [2:0]  mode_strap;
  logic        rx_err;
  logic        rxer_o;
  logic        rxer_oe;
  logic        reg_we;
  logic [4:0]  reg_wsel;
  logic [15:0] reg_wdata;
  logic [4:0]  reg_rsel;
  logic [15:0] reg_rdata;
  logic        frame_valid;
  logic [4:0]  frame_addr;
  logic        frame_is_write;
  logic        frame_match;
  logic [2:0]  mode_cfg;
  logic [4:0]  scr_seed;

  int n_chk;
  int n_bad;
  bit done;

  phy_strap_cfg dut (
    .clk(clk), .rst_n(rst_n), .strap_rxer_i(strap_rxer_i), .mode_strap(mode_strap),
    .rx_err(rx_err), .rxer_o(rxer_o), .rxer_oe(rxer_oe), .reg_we(reg_we),
    .reg_wsel(reg_wsel), .reg_wdata(reg_wdata), .reg_rsel(reg_rsel),
    .reg_rdata(reg_rdata), .frame_valid(frame_valid), .frame_addr(frame_addr),
    .frame_is_write(frame_is_write), .frame_match(frame_match),
    .mode_cfg(mode_cfg), .scr_seed(scr_seed)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [4:0] sel, input logic [15:0] data);
    @(negedge clk);
    reg_we = 1'b1; reg_wsel = sel; reg_wdata = data;
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic read_reg(input logic [4:0] sel, output logic [15:0] val);
    reg_rsel = sel;
    #1;
    val = reg_rdata;
  endtask

  task automatic hw_reset(input logic s, input logic [2:0] m);
    logic [15:0] rv;
    @(negedge clk);
    rst_n = 1'b0; strap_rxer_i = s; mode_strap = m; rx_err = 1'b1;
    #1;
    check("R3 oe low in reset", {31'd0, rxer_oe}, 32'd0);
    check("R3 out low in reset", {31'd0, rxer_o}, 32'd0);
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R3 oe low before capture", {31'd0, rxer_oe}, 32'd0);
    @(negedge clk);
    read_reg(5'd18, rv);
    check("R1 R2 strap capture", {16'd0, rv}, {16'd0, 8'd0, m, 4'd0, s});
    check("R10 seed after reset", {27'd0, scr_seed}, {27'd0, 4'd0, s});
    check("R2 mode_cfg", {29'd0, mode_cfg}, {29'd0, m});
    check("R3 oe after capture", {31'd0, rxer_oe}, 32'd1);
    check("R3 rxer follows 1", {31'd0, rxer_o}, 32'd1);
    rx_err = 1'b0;
    #1;
    check("R3 rxer follows 0", {31'd0, rxer_o}, 32'd0);
  endtask

  initial begin
    logic [15:0] rv;
    n_chk = 0; n_bad = 0; done = 1'b0;
    rst_n = 1'b0; strap_rxer_i = 1'b0; mode_strap = '0; rx_err = 1'b0;
    reg_we = 1'b0; reg_wsel = '0; reg_wdata = '0; reg_rsel = '0;
    frame_valid = 1'b0; frame_addr = '0; frame_is_write = 1'b0;

    // R1 R2 R3: every strap combination
    for (int s = 0; s < 2; s++)
      for (int m = 0; m < 8; m++)
        hw_reset(s[0], m[2:0]);

    // R11: unused registers and reset bypass
    read_reg(5'd17, rv);
    check("R11 reg17 after reset", {16'd0, rv}, 32'd0);
    read_reg(5'd3, rv);
    check("R11 other reg zero", {16'd0, rv}, 32'd0);

    // R4 R5 R7 R8 R9 R10 R11: full match sweep
    for (int sa = 0; sa < 32; sa++) begin
      for (int b = 0; b < 2; b++) begin
        reg_write(5'd18, {8'hFF, sa[2:0], sa[4:0]});
        reg_write(5'd17, {12'hFFF, b[0], 3'b111});
        read_reg(5'd18, rv);
        check("R4 R11 reg18 readback", {16'd0, rv}, {16'd0, 8'd0, sa[2:0], sa[4:0]});
        read_reg(5'd17, rv);
        check("R5 R11 reg17 readback", {16'd0, rv}, {16'd0, 12'd0, b[0], 3'd0});
        check("R10 seed", {27'd0, scr_seed}, {27'd0, sa[4:0]});
        for (int fa = 0; fa < 32; fa++)
          for (int w = 0; w < 2; w++)
            for (int v = 0; v < 2; v++) begin
              logic exp;
              frame_addr = fa[4:0]; frame_is_write = w[0]; frame_valid = v[0];
              #1;
              exp = v[0] && ((fa == sa) || (b == 1 && w == 1));
              check("R7 R8 R9 match", {31'd0, frame_match}, {31'd0, exp});
            end
      end
    end
    frame_valid = 1'b0;

    // R6: soft reset with moved straps
    reg_write(5'd18, {8'd0, 3'd6, 5'd21});
    reg_write(5'd17, 16'h0008);
    strap_rxer_i = 1'b1; mode_strap = 3'd1;
    reg_write(5'd0, 16'h0000);
    read_reg(5'd17, rv);
    check("R6 ctrl write without bit15 keeps bypass", {16'd0, rv}, 32'h8);
    reg_write(5'd0, 16'h8000);
    read_reg(5'd18, rv);
    check("R6 soft reset keeps reg18", {16'd0, rv}, {16'd0, 8'd0, 3'd6, 5'd21});
    read_reg(5'd17, rv);
    check("R6 soft reset clears bypass", {16'd0, rv}, 32'd0);
    check("R6 mode not resampled", {29'd0, mode_cfg}, 32'd6);
    frame_valid = 1'b1; frame_is_write = 1'b1; frame_addr = 5'd2;
    #1;
    check("R8 bypass gone after soft reset", {31'd0, frame_match}, 32'd0);
    frame_valid = 1'b0;
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual running expected done");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule